// File: doc/BRIEF.md
# Eight-Pin General-Purpose I/O Port with Pad Input Synchronizer

This block serves one port of up to eight general-purpose pins. Each pin has three bits: a direction bit, an output bit and a read-back bit. When the output bit belongs to an input pin, it acts as a pull-up request. From the direction bit, the output bit and a chip-wide pull-up kill input, the block works out three pad controls for each pin: the output enable, the driven level and the pull-up enable.

The pad level comes back through a two-stage synchronizer. The first stage is transparent while the clock is high and holds while the clock is low. The second stage is a rising-edge register. The read-back value therefore lags the pad by half a cycle to one and a half cycles, depending on where in the clock period the pad changes. A level that the port drives itself is read back one cycle after the write that set it.

Software reaches the direction and output registers through a small register port. A two-bit address selects the register, and the same port reads the synchronized pin value. Writes take effect on the rising edge. Reads are combinational.

Top module: `gpio_port_top`

## Requirements
- R1: While reset is held, and after it is released, the direction and output registers are zero, padOe is 0 and padPullEn is 0 on every pin.
- R2: A pin with direction 0 and output bit 0 has padOe=0 and padPullEn=0.
- R3: A pin with direction 0 and output bit 1 has padOe=0. Its padPullEn is 1 when pullupOff=0 and 0 when pullupOff=1.
- R4: A pin with direction 1 has padOe=1, padPullEn=0 and padOut equal to its output bit, for either value of pullupOff. padOut is 0 on pins with direction 0.
- R5: A write with wrEn=1 loads wrData at the rising edge. Address 0 is the direction register and address 1 is the output register. rdData returns address 0 or 1 in the same cycle, with no delay.
- R6: Address 2 returns the synchronized pad input for every pin, whatever its direction.
- R7: A pad change made while the clock is high appears at address 2 after the next rising edge. This is less than one cycle after the change.
- R8: A pad change made while the clock is low is not visible after the next rising edge. It appears after the rising edge that follows, up to one and a half cycles after the change.
- R9: When the pad is tied to padOut, a new output value written at edge E reads back at address 2 after edge E+1. A read between E and E+1 returns the previous value.
- R10: A write to address 2 or 3 leaves the direction and output registers unchanged. Address 3 reads as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 2 | Register select: 0 direction, 1 output, 2 pin read, 3 unused |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Combinational read data for addr |
| pullupOff | input | 1 | Chip-wide pull-up disable |
| padIn | input | 8 | Level seen at each pad |
| padOut | output | 8 | Level driven onto each pad |
| padOe | output | 8 | Per-pin output enable |
| padPullEn | output | 8 | Per-pin pull-up enable |

## Verification
A write to the output register and the synchronizer capture of the same pin can fall in one cycle. The bench provokes this by looping padOut back to padIn and writing a new output pattern. It reads address 2 in the cycle right after the write edge, where the old pattern must appear. It reads again after the following edge, where the new pattern must appear. It also places external pad edges half a nanosecond after a rising edge and half a nanosecond after a falling edge. For each placement, it judges the read-back on both sides of the rising edge where the new value should first appear.

// File: rtl/gpio_port_pkg.sv
`timescale 1ns/1ps
package gpio_port_pkg;

  // Register select codes on the addr port.
  typedef enum logic [1:0] {
    SEL_DIR  = 2'd0,
    SEL_OUT  = 2'd1,
    SEL_PIN  = 2'd2,
    SEL_NONE = 2'd3
  } regSel_e;

  // Strobes from the control decoder to the datapath.
  typedef struct packed {
    logic    dirWr;
    logic    outWr;
    regSel_e rdSel;
  } ctrlStrobe_t;

endpackage

// File: rtl/gpio_port_ctrl.sv
`timescale 1ns/1ps
module gpio_port_ctrl
  import gpio_port_pkg::*;
(
  input  logic        wrEn,
  input  logic [1:0]  addr,
  output ctrlStrobe_t strobe
);

  regSel_e selCode;

  always_comb begin
    selCode      = regSel_e'(addr);
    strobe.dirWr = wrEn && (selCode == SEL_DIR);
    strobe.outWr = wrEn && (selCode == SEL_OUT);
    strobe.rdSel = selCode;
  end

endmodule

// File: rtl/gpio_port_datapath.sv
`timescale 1ns/1ps
module gpio_port_datapath
  import gpio_port_pkg::*;
#(
  parameter int PINS = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctrlStrobe_t     strobe,
  input  logic [PINS-1:0] wrData,
  output logic [PINS-1:0] rdData,
  input  logic            pullupOff,
  input  logic [PINS-1:0] padIn,
  output logic [PINS-1:0] padOut,
  output logic [PINS-1:0] padOe,
  output logic [PINS-1:0] padPullEn
);

  localparam logic [PINS-1:0] ALL_ZERO = '0;

  logic [PINS-1:0] dirReg;
  logic [PINS-1:0] outReg;
  logic [PINS-1:0] pinReg;

  // Software-visible direction and output registers.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirReg <= ALL_ZERO;
      outReg <= ALL_ZERO;
    end else begin
      if (strobe.dirWr) dirReg <= wrData;
      if (strobe.outWr) outReg <= wrData;
    end
  end

  // Per-pin pad decode and two-phase input synchronizer.
  for (genvar g = 0; g < PINS; g++) begin : g_pin
    logic holdBit;
    logic pinBit;

    // The first stage is transparent while clk is high, so its output just
    // before a rising edge equals the pad level it held at the falling edge.
    // Modelling it as a falling-edge store gives the same value at the
    // rising-edge register, with no race against the edge that reopens it.
    always_ff @(negedge clk or negedge rstN) begin
      if (!rstN) holdBit <= 1'b0;
      else       holdBit <= padIn[g];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) pinBit <= 1'b0;
      else       pinBit <= holdBit;
    end

    assign pinReg[g]    = pinBit;
    assign padOe[g]     = dirReg[g];
    assign padOut[g]    = dirReg[g] & outReg[g];
    assign padPullEn[g] = ~dirReg[g] & outReg[g] & ~pullupOff;
  end

  always_comb begin
    unique case (strobe.rdSel)
      SEL_DIR: rdData = dirReg;
      SEL_OUT: rdData = outReg;
      SEL_PIN: rdData = pinReg;
      default: rdData = ALL_ZERO;
    endcase
  end

endmodule

// File: rtl/gpio_port_top.sv
`timescale 1ns/1ps
module gpio_port_top
  import gpio_port_pkg::*;
#(
  parameter int PINS = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            wrEn,
  input  logic [1:0]      addr,
  input  logic [PINS-1:0] wrData,
  output logic [PINS-1:0] rdData,
  input  logic            pullupOff,
  input  logic [PINS-1:0] padIn,
  output logic [PINS-1:0] padOut,
  output logic [PINS-1:0] padOe,
  output logic [PINS-1:0] padPullEn
);

  ctrlStrobe_t strobe;

  gpio_port_ctrl ctrl_i (
    .wrEn   (wrEn),
    .addr   (addr),
    .strobe (strobe)
  );

  gpio_port_datapath #(.PINS(PINS)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .wrData    (wrData),
    .rdData    (rdData),
    .pullupOff (pullupOff),
    .padIn     (padIn),
    .padOut    (padOut),
    .padOe     (padOe),
    .padPullEn (padPullEn)
  );

endmodule

// File: rtl/gpio_port_chk.sv
`timescale 1ns/1ps
module gpio_port_chk #(
  parameter int PINS = 8
) (
  input logic            clk,
  input logic            rstN,
  input logic            wrEn,
  input logic [1:0]      addr,
  input logic [PINS-1:0] wrData,
  input logic            pullupOff,
  input logic [PINS-1:0] padOut,
  input logic [PINS-1:0] padOe,
  input logic [PINS-1:0] padPullEn
);

  // R3/R4: a pull-up never coexists with an active driver.
  a_r4_no_pull_on_output: assert property (@(posedge clk) disable iff (!rstN)
    (padPullEn & padOe) == '0);

  // R3: the chip-wide disable suppresses every pull-up.
  a_r3_pulloff_kills_pull: assert property (@(posedge clk) disable iff (!rstN)
    pullupOff |-> (padPullEn == '0));

  // R5: a direction write shows on the enables after the edge.
  a_r5_dir_write_lands: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 2'd0) |=> (padOe == $past(wrData)));

  // R5/R4: an output write shows on the driven level of output pins.
  a_r5_out_write_lands: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 2'd1) |=> (padOut == ($past(wrData) & padOe)));

  // R10: writes to unused addresses change no pad control.
  a_r10_dead_write: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr[1]) |=> ($stable(padOe) && $stable(padOut)));

endmodule

bind gpio_port_top gpio_port_chk #(.PINS(PINS)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .wrEn      (wrEn),
  .addr      (addr),
  .wrData    (wrData),
  .pullupOff (pullupOff),
  .padOut    (padOut),
  .padOe     (padOe),
  .padPullEn (padPullEn)
);

// File: tb/gpio_port_top_tb_top.sv
`timescale 1ns/1ps
module gpio_port_top_tb_top;

  localparam int PINS = 8;

  // Signal codes used by the scoreboard.
  localparam int SIG_RD   = 0;
  localparam int SIG_OE   = 1;
  localparam int SIG_OUT  = 2;
  localparam int SIG_PULL = 3;

  typedef struct {
    string      req;
    int         sig;
    logic [7:0] exp;
  } sbItem_t;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            wrEn = 1'b0;
  logic [1:0]      addr = 2'd0;
  logic [PINS-1:0] wrData = '0;
  logic [PINS-1:0] rdData;
  logic            pullupOff = 1'b0;
  logic [PINS-1:0] padIn;
  logic [PINS-1:0] padOut;
  logic [PINS-1:0] padOe;
  logic [PINS-1:0] padPullEn;
  logic [PINS-1:0] extPad = '0;
  logic            loopMode = 1'b0;

  int applied = 0;
  int failed  = 0;
  bit done    = 1'b0;
  sbItem_t sb[$];

  always #2 clk = ~clk;

  assign padIn = loopMode ? padOut : extPad;

  gpio_port_top #(.PINS(PINS)) dut_i (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .addr      (addr),
    .wrData    (wrData),
    .rdData    (rdData),
    .pullupOff (pullupOff),
    .padIn     (padIn),
    .padOut    (padOut),
    .padOe     (padOe),
    .padPullEn (padPullEn)
  );

  // Monitor: pops expected items and compares against the live outputs.
  initial begin
    forever begin
      wait (sb.size() > 0);
      begin
        sbItem_t it;
        logic [7:0] act;
        it = sb.pop_front();
        case (it.sig)
          SIG_RD:   act = rdData;
          SIG_OE:   act = padOe;
          SIG_OUT:  act = padOut;
          default:  act = padPullEn;
        endcase
        applied++;
        if (act !== it.exp) begin
          failed++;
          $display("FAIL %s sig=%0d actual=%02h expected=%02h at %0t",
                   it.req, it.sig, act, it.exp, $time);
        end
      end
    end
  end

  task automatic expectVal(input string req, input int sig, input logic [7:0] exp);
    sbItem_t it;
    it.req = req; it.sig = sig; it.exp = exp;
    sb.push_back(it);
    wait (sb.size() == 0);
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [7:0] d);
    addr = a; wrData = d; wrEn = 1'b1;
    tick();
    wrEn = 1'b0;
  endtask

  task automatic readCheck(input string req, input logic [1:0] a, input logic [7:0] exp);
    addr = a;
    #0.1;
    expectVal(req, SIG_RD, exp);
  endtask

  // Expected pad controls, from the decode rules of R2..R4.
  task automatic checkDecode(input string req, input logic [7:0] dir,
                             input logic [7:0] outv, input logic off);
    expectVal(req, SIG_OE, dir);
    expectVal(req, SIG_OUT, dir & outv);
    expectVal(req, SIG_PULL, ~dir & outv & {8{~off}});
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      failed++;
      applied++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", applied, failed);
      $finish;
    end
  end

  initial begin
    // R1: outputs quiet while reset is held and after release
    #3;
    expectVal("R1", SIG_OE, 8'h00);
    expectVal("R1", SIG_PULL, 8'h00);
    tick();
    rstN = 1'b1;
    tick();
    readCheck("R1", 2'd0, 8'h00);
    readCheck("R1", 2'd1, 8'h00);
    expectVal("R1", SIG_OE, 8'h00);

    // R5: writes land at the edge, reads are immediate
    regWrite(2'd0, 8'hF0);
    readCheck("R5", 2'd0, 8'hF0);
    regWrite(2'd1, 8'hCC);
    readCheck("R5", 2'd1, 8'hCC);

    // R2 R3 R4: every decode row at once (pins 7:6, 5:4, 3:2, 1:0)
    pullupOff = 1'b0;
    #0.1;
    checkDecode("R2_R3_R4", 8'hF0, 8'hCC, 1'b0);
    pullupOff = 1'b1;
    #0.1;
    checkDecode("R3_R4", 8'hF0, 8'hCC, 1'b1);
    pullupOff = 1'b0;
    regWrite(2'd0, 8'h0F);
    regWrite(2'd1, 8'h5A);
    checkDecode("R2_R3_R4", 8'h0F, 8'h5A, 1'b0);

    // R10: writes to addresses 2 and 3 are ignored
    regWrite(2'd2, 8'hFF);
    regWrite(2'd3, 8'hFF);
    readCheck("R10", 2'd0, 8'h0F);
    readCheck("R10", 2'd1, 8'h5A);
    readCheck("R10", 2'd3, 8'h00);
    checkDecode("R10", 8'h0F, 8'h5A, 1'b0);

    // R6: pin read follows pad whatever the direction
    extPad = 8'h3C;
    tick(); tick();
    readCheck("R6", 2'd2, 8'h3C);

    // R7: change during the high phase, visible after the next rising edge
    @(posedge clk); #0.5;
    extPad = 8'hA1;
    addr = 2'd2;
    #3;
    expectVal("R7", SIG_RD, 8'h3C);
    #1;
    expectVal("R7", SIG_RD, 8'hA1);

    // R8: change during the low phase, needs the second rising edge
    @(negedge clk); #0.5;
    extPad = 8'h4E;
    #2;
    expectVal("R8", SIG_RD, 8'hA1);
    #4;
    expectVal("R8", SIG_RD, 8'h4E);

    // R9: readback of a written output through the loop
    loopMode = 1'b1;
    regWrite(2'd0, 8'hFF);
    regWrite(2'd1, 8'h00);
    tick(); tick();
    readCheck("R9", 2'd2, 8'h00);
    addr = 2'd1; wrData = 8'hA5; wrEn = 1'b1;
    tick();
    wrEn = 1'b0;
    readCheck("R9", 2'd2, 8'h00);
    tick();
    readCheck("R9", 2'd2, 8'hA5);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, failed);
    $finish;
  end

endmodule